// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Field Wildcards

This block checks whether a programmed alarm time matches the clock's time once each second. The clock's seconds counter produces an update strobe. On the rising edge of that strobe the block compares three alarm bytes (seconds, minutes, hours) with the three time bytes.

Both sides of each comparison are first brought to a plain binary value. The data-mode input chooses between BCD and binary decoding. In 12-hour mode the hour is also folded onto a 0..23 scale. An alarm byte whose two top bits are both set is a wildcard and matches any time value. With wildcards the alarm can fire once a day, once an hour, once a minute or once a second.

For each update the block emits a one-cycle `tick_done` pulse. When the alarm also matches, it emits `alarm_hit` in the same cycle. Both pulses go to the interrupt flag logic, which sits outside this block together with the bus interface.

Top module: `rtc_alarm_match`

## Requirements
- R1: After a synchronous active-low reset, `alarm_hit` and `tick_done` are both 0.
- R2: An alarm byte with bits [7:6] = 2'b11 matches any value of its time field. An alarm byte without that pattern must equal the time field after normalisation.
- R3: When all three alarm bytes are wildcards, every accepted update produces `alarm_hit`.
- R4: With `bin_mode` = 0, each byte is decoded as BCD: upper nibble × 10 + lower nibble. With `bin_mode` = 1, the byte is taken as a binary value.
- R5: With `h24_mode` = 0, bit 7 of an hour byte is the PM flag. The flag is removed before decoding. The decoded hour is reduced modulo 12, and 12 is added when the flag is set. This applies to the alarm hour and the time hour alike, so BCD 0x12 (12 AM) equals hour 0.
- R6: With `h24_mode` = 1, the whole hour byte is decoded with no PM handling.
- R7: An update is accepted on the first cycle in which `upd_stb` is sampled high after a cycle in which it was low. One cycle later `tick_done` is 1. `alarm_hit` is 1 in that same cycle when all three fields match.
- R8: Each accepted update gives exactly one cycle of `tick_done` and at most one cycle of `alarm_hit`, however long `upd_stb` stays high.
- R9: While `clk_hold` is 1 at the strobe's rising edge, neither `tick_done` nor `alarm_hit` is produced.
- R10: Alarm bytes are sampled at the update edge, so a new alarm value written between updates decides the next update.
- R11: A mismatch in any single non-wildcard field suppresses `alarm_hit` while `tick_done` is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_stb | input | 1 | Once-per-second update strobe; its rising edge starts a comparison |
| clk_hold | input | 1 | Clock held for setting; suppresses both outputs |
| bin_mode | input | 1 | 1 = binary field values, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour hour byte, 0 = 12-hour with PM in bit 7 |
| tm_sec | input | 8 | Current seconds byte |
| tm_min | input | 8 | Current minutes byte |
| tm_hour | input | 8 | Current hours byte |
| al_sec | input | 8 | Alarm seconds byte |
| al_min | input | 8 | Alarm minutes byte |
| al_hour | input | 8 | Alarm hours byte |
| alarm_hit | output | 1 | One-cycle alarm match pulse |
| tick_done | output | 1 | One-cycle update-ended pulse, aligned with `alarm_hit` |

## Verification
The bench builds the block with its default parameters: 8-bit fields and three fields, with the hour in the last position. These defaults give the full byte range, so wildcard patterns, out-of-range BCD nibbles and the PM bit can all be driven. A behavioural model recomputes both pulses every cycle, and directed cases cover the 12 AM fold, the AM/PM split, the BCD/binary difference, held strobes and the hold input. Random updates then mix modes, wildcards and near-miss fields.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared constants for the alarm comparator.
// Assumes the field order seconds, minutes, hours. Only the hour field
// gets 12/24-hour treatment.
package rtc_alarm_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 3;
    localparam int HOUR_IDX   = 2;
    localparam logic [1:0] WILD_MARK = 2'b11;

    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2
    } field_e;
endpackage

// File: rtl/alarm_field_decode.sv
// Module: alarm_field_decode
// Turns one raw time or alarm byte into a binary value.
// BCD decoding is applied unless bin_mode is set. For the hour field in
// 12-hour mode, the PM bit is stripped before decoding, the value is reduced
// modulo 12, and 12 is added for PM.
// Assumes BYTE_W >= 8. Purely combinational.
module alarm_field_decode #(
    parameter int BYTE_W  = 8,
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [BYTE_W-1:0] raw,
    input  logic              bin_mode,
    input  logic              h24_mode,
    output logic [BYTE_W-1:0] norm
);
    localparam int NIB = 4;

    logic              twelve_hr;
    logic [BYTE_W-1:0] src;
    logic [BYTE_W-1:0] dec;
    logic [BYTE_W-1:0] folded;

    // Select 12-hour handling only for the hour field.
    assign twelve_hr = IS_HOUR && !h24_mode;

    // Strip the PM flag before decoding in 12-hour mode.
    always_comb begin
        src = raw;
        if (twelve_hr) src[BYTE_W-1] = 1'b0;
    end

    // BCD or binary decode.
    always_comb begin
        if (bin_mode)
            dec = src;
        else
            dec = BYTE_W'(src[2*NIB-1:NIB]) * BYTE_W'(10) + BYTE_W'(src[NIB-1:0]);
    end

    // Fold 12-hour values onto the 0..23 scale.
    always_comb begin
        folded = dec % BYTE_W'(12);
        if (raw[BYTE_W-1]) folded = folded + BYTE_W'(12);
    end

    // Pick the folded or the plain value.
    assign norm = twelve_hr ? folded : dec;
endmodule

// File: rtl/alarm_update_pulse.sv
// Module: alarm_update_pulse
// Detects the rising edge of the update strobe. One cycle later it emits
// an update pulse, plus an alarm pulse when the match input is high.
// A held clock suppresses both.
// Assumes match is valid in the cycle of the strobe's rising edge.
module alarm_update_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic hold,
    input  logic match,
    output logic hit,
    output logic tick
);
    logic stb_q;
    logic rise;

    // First high cycle of the strobe.
    assign rise = stb && !stb_q;

    // Register the previous strobe value and both output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            hit   <= 1'b0;
            tick  <= 1'b0;
        end else begin
            stb_q <= stb;
            tick  <= rise && !hold;
            hit   <= rise && !hold && match;
        end
    end

    // R8: an alarm pulse never lasts two cycles.
    a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R8: an update pulse never lasts two cycles.
    a_r8_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7: the alarm pulse always comes with the update pulse.
    a_r7_hit_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> tick);

    // R9: no pulse follows a cycle in which the clock was held.
    a_r9_no_tick_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !tick);
endmodule

// File: rtl/rtc_alarm_match.sv
// Module: rtc_alarm_match (top)
// Compares the seconds, minutes and hours alarm bytes with the current time
// bytes on each update. Every byte is normalised to binary 24-hour form
// first. Alarm bytes with both top bits set are wildcards.
// Assumes the time bytes already hold the new value when upd_stb rises.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_stb,
    input  logic              clk_hold,
    input  logic              bin_mode,
    input  logic              h24_mode,
    input  logic [BYTE_W-1:0] tm_sec,
    input  logic [BYTE_W-1:0] tm_min,
    input  logic [BYTE_W-1:0] tm_hour,
    input  logic [BYTE_W-1:0] al_sec,
    input  logic [BYTE_W-1:0] al_min,
    input  logic [BYTE_W-1:0] al_hour,
    output logic              alarm_hit,
    output logic              tick_done
);
    logic [BYTE_W-1:0]     al_b    [NUM_FIELDS];
    logic [BYTE_W-1:0]     tm_b    [NUM_FIELDS];
    logic [BYTE_W-1:0]     al_norm [NUM_FIELDS];
    logic [BYTE_W-1:0]     tm_norm [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] field_ok;
    logic                  all_ok;

    // Gather the ports into per-field arrays.
    assign al_b[FLD_SEC]  = al_sec;
    assign al_b[FLD_MIN]  = al_min;
    assign al_b[FLD_HOUR] = al_hour;
    assign tm_b[FLD_SEC]  = tm_sec;
    assign tm_b[FLD_MIN]  = tm_min;
    assign tm_b[FLD_HOUR] = tm_hour;

    // One decoder pair and one comparison per field.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        alarm_field_decode #(
            .BYTE_W (BYTE_W),
            .IS_HOUR(i == HOUR_IDX)
        ) u_al_dec (
            .raw     (al_b[i]),
            .bin_mode(bin_mode),
            .h24_mode(h24_mode),
            .norm    (al_norm[i])
        );

        alarm_field_decode #(
            .BYTE_W (BYTE_W),
            .IS_HOUR(i == HOUR_IDX)
        ) u_tm_dec (
            .raw     (tm_b[i]),
            .bin_mode(bin_mode),
            .h24_mode(h24_mode),
            .norm    (tm_norm[i])
        );

        assign field_ok[i] = (al_b[i][BYTE_W-1 -: 2] == WILD_MARK) ||
                             (al_norm[i] == tm_norm[i]);
    end

    // All fields must agree.
    assign all_ok = &field_ok;

    alarm_update_pulse u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (upd_stb),
        .hold (clk_hold),
        .match(all_ok),
        .hit  (alarm_hit),
        .tick (tick_done)
    );

    // R3: an all-wildcard alarm fires on every accepted update.
    a_r3_all_wild_fires: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(upd_stb) && !clk_hold &&
         al_sec[BYTE_W-1 -: 2] == WILD_MARK &&
         al_min[BYTE_W-1 -: 2] == WILD_MARK &&
         al_hour[BYTE_W-1 -: 2] == WILD_MARK) |=> alarm_hit);

    // R11: a mismatched seconds field blocks the alarm.
    a_r11_sec_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (al_sec[BYTE_W-1 -: 2] != WILD_MARK && al_sec == tm_sec + 8'd1 &&
         bin_mode) |=> !alarm_hit || $past(al_sec) != $past(tm_sec) + 8'd1 || !$past(bin_mode));
endmodule

// File: tb/rtc_alarm_match_test.sv
module rtc_alarm_match_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0;
    logic       clk_hold = 1'b0;
    logic       bin_mode = 1'b0;
    logic       h24_mode = 1'b1;
    logic [7:0] tm_sec = 8'h00, tm_min = 8'h00, tm_hour = 8'h00;
    logic [7:0] al_sec = 8'h00, al_min = 8'h00, al_hour = 8'h00;
    logic       alarm_hit, tick_done;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    rtc_alarm_match uut (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .clk_hold(clk_hold),
        .bin_mode(bin_mode), .h24_mode(h24_mode),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour),
        .alarm_hit(alarm_hit), .tick_done(tick_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural normalisation of one byte.
    function automatic int norm_val(int b, bit bin, bit h24, bit hr);
        int s = (hr && !h24) ? (b & 127) : b;
        int d = bin ? s : (s / 16) * 10 + (s % 16);
        if (hr && !h24) d = (d % 12) + (((b & 128) != 0) ? 12 : 0);
        return d;
    endfunction

    function automatic bit fld_ok(int a, int t, bit hr);
        if ((a & 192) == 192) return 1'b1;
        return norm_val(a, bin_mode, h24_mode, hr) == norm_val(t, bin_mode, h24_mode, hr);
    endfunction

    // Reference model, evaluated at each rising edge.
    bit m_prev = 0, m_hit = 0, m_tick = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev <= 0; m_hit <= 0; m_tick <= 0;
        end else begin
            m_prev <= upd_stb;
            m_tick <= upd_stb && !m_prev && !clk_hold;
            m_hit  <= upd_stb && !m_prev && !clk_hold &&
                      fld_ok(al_sec, tm_sec, 0) && fld_ok(al_min, tm_min, 0) &&
                      fld_ok(al_hour, tm_hour, 1);
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, "model alarm_hit", alarm_hit, m_hit);
            check(cur_req, "model tick_done", tick_done, m_tick);
        end
    end

    // Raise the strobe for hi cycles and check the literal expected pulse.
    task automatic upd(int hi, bit e_hit, bit e_tick, string req);
        cur_req = req;
        upd_stb = 1'b1;
        @(negedge clk);
        check(req, "alarm_hit", alarm_hit, e_hit);
        check(req, "tick_done", tick_done, e_tick);
        for (int k = 1; k < hi; k++) begin
            @(negedge clk);
            check("R8", "alarm_hit held", alarm_hit, 0);
            check("R8", "tick_done held", tick_done, 0);
        end
        upd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_al(logic [7:0] s, logic [7:0] m, logic [7:0] h);
        al_sec = s; al_min = m; al_hour = h;
    endtask

    task automatic set_tm(logic [7:0] s, logic [7:0] m, logic [7:0] h);
        tm_sec = s; tm_min = m; tm_hour = h;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", "reset alarm_hit", alarm_hit, 0);
        check("R1", "reset tick_done", tick_done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: all wildcards
        set_al(8'hC0, 8'hFF, 8'hC5); set_tm(8'h17, 8'h42, 8'h09);
        upd(1, 1, 1, "R3");
        set_tm(8'h18, 8'h42, 8'h09);
        upd(1, 1, 1, "R3");

        // R2: exact seconds, wild minutes and hours
        set_al(8'h30, 8'hFF, 8'hFF); set_tm(8'h30, 8'h45, 8'h11);
        upd(1, 1, 1, "R2");
        // R11: single-field mismatch, tick still produced
        set_tm(8'h31, 8'h45, 8'h11);
        upd(1, 0, 1, "R11");
        set_al(8'h30, 8'h45, 8'h12); set_tm(8'h30, 8'h45, 8'h11);
        upd(1, 0, 1, "R11");

        // R4: BCD vs binary with 12-hour hour 0x12 against 0x00
        h24_mode = 1'b0; bin_mode = 1'b0;
        set_al(8'hC0, 8'hC0, 8'h12); set_tm(8'h00, 8'h00, 8'h00);
        upd(1, 1, 1, "R4");
        bin_mode = 1'b1;
        upd(1, 0, 1, "R4");
        bin_mode = 1'b0;
        set_al(8'h25, 8'hC0, 8'hC0); set_tm(8'h25, 8'h00, 8'h00);
        upd(1, 1, 1, "R4");
        set_tm(8'h19, 8'h00, 8'h00);
        upd(1, 0, 1, "R4");

        // R5: PM flag distinguishes 7 AM from 7 PM
        set_al(8'hC0, 8'hC0, 8'h87); set_tm(8'h00, 8'h00, 8'h87);
        upd(1, 1, 1, "R5");
        set_tm(8'h00, 8'h00, 8'h07);
        upd(1, 0, 1, "R5");
        set_al(8'hC0, 8'hC0, 8'h92); set_tm(8'h00, 8'h00, 8'h80);
        upd(1, 1, 1, "R5");

        // R6: 24-hour mode decodes hour byte whole
        h24_mode = 1'b1;
        set_al(8'hC0, 8'hC0, 8'h12); set_tm(8'h00, 8'h00, 8'h00);
        upd(1, 0, 1, "R6");
        set_al(8'hC0, 8'hC0, 8'h23); set_tm(8'h00, 8'h00, 8'h23);
        upd(1, 1, 1, "R6");

        // R7 and R8: held strobe gives one aligned pulse pair
        set_al(8'hFF, 8'hFF, 8'hFF);
        upd(4, 1, 1, "R7");
        upd(6, 1, 1, "R8");

        // R9: hold suppresses both pulses
        clk_hold = 1'b1;
        upd(2, 0, 0, "R9");
        clk_hold = 1'b0;
        upd(1, 1, 1, "R9");

        // R10: alarm rewritten between updates
        set_al(8'h05, 8'h10, 8'h08); set_tm(8'h06, 8'h10, 8'h08);
        upd(1, 0, 1, "R10");
        set_al(8'h06, 8'h10, 8'h08);
        upd(1, 1, 1, "R10");
        set_al(8'h07, 8'h10, 8'h08);
        upd(1, 0, 1, "R10");

        // Random updates checked against the model.
        cur_req = "R2";
        for (int n = 0; n < 500; n++) begin
            bin_mode = 1'($urandom_range(0, 1));
            h24_mode = 1'($urandom_range(0, 1));
            clk_hold = ($urandom_range(0, 9) == 0);
            tm_sec  = 8'($urandom_range(0, 255));
            tm_min  = 8'($urandom_range(0, 255));
            tm_hour = 8'($urandom_range(0, 255));
            case ($urandom_range(0, 2))
                0: al_sec = tm_sec;
                1: al_sec = 8'hC0 | 8'($urandom_range(0, 63));
                default: al_sec = 8'($urandom_range(0, 255));
            endcase
            case ($urandom_range(0, 2))
                0: al_min = tm_min;
                1: al_min = 8'hC0 | 8'($urandom_range(0, 63));
                default: al_min = 8'($urandom_range(0, 255));
            endcase
            case ($urandom_range(0, 2))
                0: al_hour = tm_hour ^ (h24_mode ? 8'h00 : 8'h00);
                1: al_hour = 8'hC0 | 8'($urandom_range(0, 63));
                default: al_hour = 8'($urandom_range(0, 255));
            endcase
            upd_stb = 1'b1;
            repeat ($urandom_range(1, 3)) @(negedge clk);
            upd_stb = 1'b0;
            @(negedge clk);
            clk_hold = 1'b0;
        end

        finish_run();
    end
endmodule